// File: doc/BRIEF.md
# Tag-Snooping Operand Capture Pool

This block is a small pool of waiting slots for one class of functional unit, such as a floating-point adder or a multiplier. An operation is accepted into a free slot together with two source operands. Each operand arrives either as a finished value or as the tag of the slot that will later produce it. While an operand is missing, the slot watches a single shared result bus every cycle. It picks up the value as soon as a result carrying the awaited tag is broadcast.

A slot whose operands are both present is offered to the functional unit through a valid/ready handshake. The offer carries the opcode, both values and the slot's own tag. When several slots qualify, the one accepted earliest goes first. The unit takes one operation and becomes eligible for the next only in the cycle after its result has been broadcast. The same broadcast releases the producing slot for reuse. The issuing logic reads the tag of the slot that would be assigned, so it can record where the result will come from.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is free, `iss_ready` is 1, `iss_tag` equals `TAG_BASE` and `disp_valid` is 0.
- R2: When every slot is busy, `iss_ready` is 0. An issue attempt in that state takes no slot, and its operation is never offered to the unit.
- R3: An operand tag of 0 means the accompanying value is valid and is stored directly. A nonzero tag names the producer, and the slot waits for it.
- R4: A broadcast whose tag matches a waiting operand fills that operand in every waiting slot at the same clock edge. A slot whose last operand arrives this way may be offered from the next cycle.
- R5: A slot is offered only when both operands hold values and the unit is free. The offer carries the slot's opcode, operand values and tag, and it stays pending while `disp_ready` is 0.
- R6: After a handshake, `disp_valid` stays 0 until the cycle after the result with that slot's tag appears on the bus, including during the broadcast cycle itself.
- R7: Among slots that are ready together, the one accepted earliest is offered first, whatever its index.
- R8: If a producer's result is on the bus in the same cycle an operand naming that producer is issued, the value is stored at issue and the operand does not wait.
- R9: Slot i carries tag `TAG_BASE`+i. It stays busy until its own tag is broadcast, and an issue always takes the lowest-index free slot, reported on `iss_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation is presented for acceptance |
| iss_ready | output | 1 | At least one slot is free |
| iss_tag | output | TAG_W | Tag of the slot the next accepted operation takes |
| iss_op | input | OP_W | Opcode of the presented operation |
| iss_a_tag | input | TAG_W | Producer tag of operand A, 0 if the value is valid |
| iss_a_val | input | DATA_W | Value of operand A |
| iss_b_tag | input | TAG_W | Producer tag of operand B, 0 if the value is valid |
| iss_b_val | input | DATA_W | Value of operand B |
| cdb_valid | input | 1 | A result is on the shared bus |
| cdb_tag | input | TAG_W | Tag of the slot that produced the result |
| cdb_val | input | DATA_W | Result value |
| disp_valid | output | 1 | A ready slot is offered to the unit |
| disp_ready | input | 1 | The unit accepts the offer |
| disp_op | output | OP_W | Opcode of the offered slot |
| disp_a | output | DATA_W | Operand A value of the offered slot |
| disp_b | output | DATA_W | Operand B value of the offered slot |
| disp_tag | output | TAG_W | Tag of the offered slot |

## Verification
The stimulus covers five operand patterns. Fully valid operands separate the direct path from tag waiting. Two slots waiting on one producer show whether a single broadcast fills every matching slot at the same edge. A result arriving in the very cycle of issue exposes a stale tag left behind. A full pool held back by one producer separates stall behaviour from a silently dropped or duplicated operation. A handshake held low while the lowest slot is freed and refilled makes acceptance order differ from index order, so age ordering cannot be confused with fixed priority.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
   typedef enum logic {
      PICK_LOWEST = 1'b0,
      PICK_OLDEST = 1'b1
   } rsp_pick_e;
endpackage

// File: rtl/rsp_entry.sv
module rsp_entry #(
   parameter int DATA_W = 32,
   parameter int OP_W   = 4,
   parameter int TAG_W  = 4,
   parameter logic [TAG_W-1:0] MY_TAG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [OP_W-1:0]   in_op,
   input  logic [TAG_W-1:0]  in_a_tag,
   input  logic [DATA_W-1:0] in_a_val,
   input  logic [TAG_W-1:0]  in_b_tag,
   input  logic [DATA_W-1:0] in_b_val,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_val,
   input  logic              launch,
   output logic              busy,
   output logic              ready,
   output logic              a_wait,
   output logic              b_wait,
   output logic [OP_W-1:0]   op,
   output logic [DATA_W-1:0] a_val,
   output logic [DATA_W-1:0] b_val
);
   logic              busy_q, sent_q;
   logic [TAG_W-1:0]  a_tag_q, b_tag_q;
   logic [OP_W-1:0]   op_q;
   logic [DATA_W-1:0] a_val_q, b_val_q;

   // bus hits for operands at issue and while waiting
   logic hit_a_in, hit_b_in, hit_a_q, hit_b_q, hit_self;
   assign hit_a_in = cdb_valid && (cdb_tag == in_a_tag);
   assign hit_b_in = cdb_valid && (cdb_tag == in_b_tag);
   assign hit_a_q  = cdb_valid && (a_tag_q != '0) && (cdb_tag == a_tag_q);
   assign hit_b_q  = cdb_valid && (b_tag_q != '0) && (cdb_tag == b_tag_q);
   assign hit_self = cdb_valid && (cdb_tag == MY_TAG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         sent_q  <= 1'b0;
         op_q    <= '0;
         a_tag_q <= '0;
         b_tag_q <= '0;
         a_val_q <= '0;
         b_val_q <= '0;
      end else if (alloc) begin
         busy_q <= 1'b1;
         sent_q <= 1'b0;
         op_q   <= in_op;
         if (in_a_tag == '0) begin
            a_tag_q <= '0;
            a_val_q <= in_a_val;
         end else if (hit_a_in) begin
            a_tag_q <= '0;
            a_val_q <= cdb_val;
         end else begin
            a_tag_q <= in_a_tag;
         end
         if (in_b_tag == '0) begin
            b_tag_q <= '0;
            b_val_q <= in_b_val;
         end else if (hit_b_in) begin
            b_tag_q <= '0;
            b_val_q <= cdb_val;
         end else begin
            b_tag_q <= in_b_tag;
         end
      end else if (busy_q) begin
         if (hit_a_q) begin
            a_tag_q <= '0;
            a_val_q <= cdb_val;
         end
         if (hit_b_q) begin
            b_tag_q <= '0;
            b_val_q <= cdb_val;
         end
         if (launch) sent_q <= 1'b1;
         if (hit_self) busy_q <= 1'b0;
      end
   end

   assign busy   = busy_q;
   assign a_wait = busy_q && (a_tag_q != '0);
   assign b_wait = busy_q && (b_tag_q != '0);
   assign ready  = busy_q && !sent_q && (a_tag_q == '0) && (b_tag_q == '0);
   assign op     = op_q;
   assign a_val  = a_val_q;
   assign b_val  = b_val_q;
endmodule

// File: rtl/rsp_pick.sv
module rsp_pick
   import rsp_pkg::*;
#(
   parameter int        N    = 4,
   parameter rsp_pick_e MODE = PICK_OLDEST
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] alloc,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   generate
      if (MODE == PICK_OLDEST) begin : g_age
         // older_q[i][j] set: slot i was accepted before slot j
         logic [N-1:0] older_q [N];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < N; i++) older_q[i] <= '0;
            end else begin
               for (int i = 0; i < N; i++) begin
                  for (int j = 0; j < N; j++) begin
                     if (alloc[j] && (i != j)) older_q[i][j] <= 1'b1;
                     else if (alloc[i])        older_q[i][j] <= 1'b0;
                  end
               end
            end
         end

         always_comb begin
            for (int i = 0; i < N; i++) begin
               logic blocked;
               blocked = 1'b0;
               for (int j = 0; j < N; j++) begin
                  if ((j != i) && req[j] && older_q[j][i]) blocked = 1'b1;
               end
               grant[i] = req[i] && !blocked;
            end
         end
      end else begin : g_low
         assign grant = req & (~req + N'(1));
      end
   endgenerate
endmodule

// File: rtl/rs_pool.sv
module rs_pool
   import rsp_pkg::*;
#(
   parameter int        NUM_ST   = 4,
   parameter int        DATA_W   = 32,
   parameter int        OP_W     = 4,
   parameter int        TAG_W    = 4,
   parameter int        TAG_BASE = 1,
   parameter rsp_pick_e PICK     = PICK_OLDEST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   output logic              iss_ready,
   output logic [TAG_W-1:0]  iss_tag,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [TAG_W-1:0]  iss_a_tag,
   input  logic [DATA_W-1:0] iss_a_val,
   input  logic [TAG_W-1:0]  iss_b_tag,
   input  logic [DATA_W-1:0] iss_b_val,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_val,
   output logic              disp_valid,
   input  logic              disp_ready,
   output logic [OP_W-1:0]   disp_op,
   output logic [DATA_W-1:0] disp_a,
   output logic [DATA_W-1:0] disp_b,
   output logic [TAG_W-1:0]  disp_tag
);
   localparam int IDX_W = (NUM_ST > 1) ? $clog2(NUM_ST) : 1;

   generate
      if (NUM_ST < 2) begin : g_bad_depth
         $error("rs_pool: NUM_ST must be at least 2");
      end
      if (TAG_BASE < 1) begin : g_bad_base
         $error("rs_pool: TAG_BASE must be nonzero, tag 0 marks a valid value");
      end
      if (TAG_BASE + NUM_ST > (1 << TAG_W)) begin : g_bad_tagw
         $error("rs_pool: TAG_W too narrow for the slot tags");
      end
   endgenerate

   logic [NUM_ST-1:0] busy, rdy, a_wait, b_wait, alloc, grant, launch, free_one;
   logic [OP_W-1:0]   op_arr [NUM_ST];
   logic [DATA_W-1:0] a_arr  [NUM_ST];
   logic [DATA_W-1:0] b_arr  [NUM_ST];
   logic [IDX_W-1:0]  free_idx, grant_idx;
   logic              fu_busy_q;
   logic [TAG_W-1:0]  run_tag_q;
   logic              disp_fire;

   // lowest-index free slot
   assign free_one  = ~busy & (busy + NUM_ST'(1));
   assign iss_ready = |(~busy);
   assign alloc     = (iss_valid && iss_ready) ? free_one : '0;

   always_comb begin
      free_idx = '0;
      for (int i = 0; i < NUM_ST; i++) begin
         if (free_one[i]) free_idx = IDX_W'(i);
      end
   end
   assign iss_tag = TAG_W'(TAG_BASE) + TAG_W'(free_idx);

   generate
      for (genvar i = 0; i < NUM_ST; i++) begin : g_slot
         rsp_entry #(
            .DATA_W (DATA_W),
            .OP_W   (OP_W),
            .TAG_W  (TAG_W),
            .MY_TAG (TAG_W'(TAG_BASE + i))
         ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc[i]),
            .in_op     (iss_op),
            .in_a_tag  (iss_a_tag),
            .in_a_val  (iss_a_val),
            .in_b_tag  (iss_b_tag),
            .in_b_val  (iss_b_val),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_val   (cdb_val),
            .launch    (launch[i]),
            .busy      (busy[i]),
            .ready     (rdy[i]),
            .a_wait    (a_wait[i]),
            .b_wait    (b_wait[i]),
            .op        (op_arr[i]),
            .a_val     (a_arr[i]),
            .b_val     (b_arr[i])
         );
      end
   endgenerate

   rsp_pick #(
      .N    (NUM_ST),
      .MODE (PICK)
   ) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .alloc (alloc),
      .req   (rdy),
      .grant (grant)
   );

   assign disp_valid = (|rdy) && !fu_busy_q;
   assign disp_fire  = disp_valid && disp_ready;
   assign launch     = disp_fire ? grant : '0;

   always_comb begin
      grant_idx = '0;
      disp_op   = '0;
      disp_a    = '0;
      disp_b    = '0;
      for (int i = 0; i < NUM_ST; i++) begin
         if (grant[i]) begin
            grant_idx = IDX_W'(i);
            disp_op   = op_arr[i];
            disp_a    = a_arr[i];
            disp_b    = b_arr[i];
         end
      end
   end
   assign disp_tag = TAG_W'(TAG_BASE) + TAG_W'(grant_idx);

   // unit occupancy: freed by the broadcast of the running tag
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fu_busy_q <= 1'b0;
         run_tag_q <= '0;
      end else if (disp_fire) begin
         fu_busy_q <= 1'b1;
         run_tag_q <= disp_tag;
      end else if (cdb_valid && (cdb_tag == run_tag_q)) begin
         fu_busy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
   parameter int N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         iss_ready,
   input logic         cdb_valid,
   input logic         disp_valid,
   input logic         disp_ready,
   input logic [N-1:0] busy,
   input logic [N-1:0] alloc,
   input logic [N-1:0] grant,
   input logic [N-1:0] a_wait,
   input logic [N-1:0] b_wait
);
   a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> ($countones(grant) == 1));

   a_r5_operands_present: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> ((grant & (a_wait | b_wait)) == '0));

   a_r6_unit_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ready) |=> !disp_valid);

   a_r9_free_needs_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
      !cdb_valid |=> (($past(busy) & ~busy) == '0));

   a_r2_alloc_into_free: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc & busy) == '0);

   a_r2_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_ready |-> (alloc == '0));
endmodule

bind rs_pool rs_pool_chk #(.N(NUM_ST)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .iss_ready  (iss_ready),
   .cdb_valid  (cdb_valid),
   .disp_valid (disp_valid),
   .disp_ready (disp_ready),
   .busy       (busy),
   .alloc      (alloc),
   .grant      (grant),
   .a_wait     (a_wait),
   .b_wait     (b_wait)
);

// File: tb/rs_pool_bench.sv
module rs_pool_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        iss_valid, iss_ready;
   logic [3:0]  iss_tag, iss_op, iss_a_tag, iss_b_tag;
   logic [31:0] iss_a_val, iss_b_val;
   logic        cdb_valid;
   logic [3:0]  cdb_tag;
   logic [31:0] cdb_val;
   logic        disp_valid, disp_ready;
   logic [3:0]  disp_op, disp_tag;
   logic [31:0] disp_a, disp_b;

   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [3:0]  tag;
   } item_t;
   item_t exp_q[$];

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rs_pool u_rs_pool (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
      .iss_op(iss_op), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
      .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
      .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
      .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
   );

   task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic issue(input logic [3:0] op, input logic [3:0] at, input logic [31:0] av,
                        input logic [3:0] bt, input logic [31:0] bv);
      iss_valid = 1'b1; iss_op = op;
      iss_a_tag = at; iss_a_val = av;
      iss_b_tag = bt; iss_b_val = bv;
      tick();
      iss_valid = 1'b0;
   endtask

   task automatic bcast(input logic [3:0] tag, input logic [31:0] val);
      cdb_valid = 1'b1; cdb_tag = tag; cdb_val = val;
      tick();
      cdb_valid = 1'b0;
   endtask

   task automatic expect_disp(input logic [3:0] op, input logic [31:0] a,
                              input logic [31:0] b, input logic [3:0] tag);
      item_t it;
      it.op = op; it.a = a; it.b = b; it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor: compares each accepted offer against the scoreboard (R5, R7)
   always @(negedge clk) begin
      if (rst_n === 1'b1 && disp_valid === 1'b1 && disp_ready === 1'b1) begin
         item_t got;
         got = {disp_op, disp_a, disp_b, disp_tag};
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected offer", 72'(got), 72'(0));
         end else begin
            item_t e;
            e = exp_q.pop_front();
            chk(got == e, "R5 R7 offer contents/order", 72'(got), 72'(e));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0;
      iss_a_tag = '0; iss_b_tag = '0; iss_a_val = '0; iss_b_val = '0;
      cdb_valid = 1'b0; cdb_tag = '0; cdb_val = '0; disp_ready = 1'b1;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(iss_ready == 1'b1, "R1 iss_ready", 72'(iss_ready), 72'(1));
      chk(iss_tag == 4'd1, "R1 iss_tag", 72'(iss_tag), 72'(1));
      chk(disp_valid == 1'b0, "R1 disp_valid", 72'(disp_valid), 72'(0));

      // R3 R5 R9: valid operands go straight through
      expect_disp(4'd1, 32'd5, 32'd7, 4'd1);
      issue(4'd1, 4'd0, 32'd5, 4'd0, 32'd7);
      chk(disp_valid == 1'b1, "R3 R5 ready operands offered", 72'(disp_valid), 72'(1));
      tick();
      chk(disp_valid == 1'b0, "R6 unit busy after handshake", 72'(disp_valid), 72'(0));
      chk(iss_tag == 4'd2, "R9 slot held until broadcast", 72'(iss_tag), 72'(2));
      bcast(4'd1, 32'd12);
      chk(iss_tag == 4'd1, "R9 slot freed by own tag", 72'(iss_tag), 72'(1));

      // R4 R6: two slots wait on producer 9
      issue(4'd5, 4'd9, 32'd0, 4'd0, 32'd3);
      issue(4'd6, 4'd0, 32'd4, 4'd9, 32'd0);
      chk(disp_valid == 1'b0, "R4 waiting operands not offered", 72'(disp_valid), 72'(0));
      expect_disp(4'd5, 32'd100, 32'd3, 4'd1);
      expect_disp(4'd6, 32'd4, 32'd100, 4'd2);
      bcast(4'd9, 32'd100);
      chk(disp_valid == 1'b1, "R4 captured next cycle", 72'(disp_valid), 72'(1));
      tick();
      chk(disp_valid == 1'b0, "R6 second slot held", 72'(disp_valid), 72'(0));
      cdb_valid = 1'b1; cdb_tag = 4'd1; cdb_val = 32'd0;
      chk(disp_valid == 1'b0, "R6 held in broadcast cycle", 72'(disp_valid), 72'(0));
      tick();
      cdb_valid = 1'b0;
      chk(disp_valid == 1'b1, "R6 free cycle after broadcast", 72'(disp_valid), 72'(1));
      tick();
      bcast(4'd2, 32'd0);

      // R7: acceptance order differs from index order
      disp_ready = 1'b0;
      issue(4'd2, 4'd0, 32'd1, 4'd0, 32'd2);
      issue(4'd3, 4'd0, 32'd3, 4'd0, 32'd4);
      chk(disp_tag == 4'd1, "R7 oldest offered", 72'(disp_tag), 72'(1));
      expect_disp(4'd2, 32'd1, 32'd2, 4'd1);
      disp_ready = 1'b1;
      tick();
      disp_ready = 1'b0;
      bcast(4'd1, 32'd0);
      chk(iss_tag == 4'd1, "R9 lowest free slot", 72'(iss_tag), 72'(1));
      issue(4'd4, 4'd0, 32'd5, 4'd0, 32'd6);
      chk(disp_tag == 4'd2 && disp_valid == 1'b1, "R7 older slot 2 before newer slot 1",
          72'(disp_tag), 72'(2));
      expect_disp(4'd3, 32'd3, 32'd4, 4'd2);
      expect_disp(4'd4, 32'd5, 32'd6, 4'd1);
      disp_ready = 1'b1;
      tick();
      bcast(4'd2, 32'd0);
      tick();
      bcast(4'd1, 32'd0);

      // R8: producer result on the bus in the issue cycle
      cdb_valid = 1'b1; cdb_tag = 4'd12; cdb_val = 32'd77;
      expect_disp(4'd7, 32'd77, 32'd8, 4'd1);
      issue(4'd7, 4'd12, 32'd0, 4'd0, 32'd8);
      cdb_valid = 1'b0;
      chk(disp_valid == 1'b1, "R8 same-cycle bypass", 72'(disp_valid), 72'(1));
      tick();
      bcast(4'd1, 32'd0);

      // R2 R4: fill the pool on one producer, then try one more
      for (int k = 0; k < 4; k++) issue(4'(8 + k), 4'd13, 32'd0, 4'd0, 32'(k + 1));
      chk(iss_ready == 1'b0, "R2 full pool stalls", 72'(iss_ready), 72'(0));
      iss_valid = 1'b1; iss_op = 4'd15;
      iss_a_tag = 4'd0; iss_a_val = 32'd99; iss_b_tag = 4'd0; iss_b_val = 32'd99;
      tick();
      iss_valid = 1'b0;
      chk(disp_valid == 1'b0, "R2 refused op not offered", 72'(disp_valid), 72'(0));
      for (int k = 0; k < 4; k++) expect_disp(4'(8 + k), 32'd50, 32'(k + 1), 4'(k + 1));
      bcast(4'd13, 32'd50);
      for (int k = 0; k < 4; k++) begin
         chk(disp_valid == 1'b1, "R4 all slots captured", 72'(disp_valid), 72'(1));
         tick();
         bcast(4'(k + 1), 32'd0);
      end
      chk(iss_ready == 1'b1 && iss_tag == 4'd1, "R2 refused op took no slot",
          72'(iss_tag), 72'(1));
      repeat (3) tick();
      chk(disp_valid == 1'b0, "R2 nothing left to offer", 72'(disp_valid), 72'(0));
      chk(exp_q.size() == 0, "R5 every expected offer seen", 72'(exp_q.size()), 72'(0));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule